// File: doc/BRIEF.md
# Three-Wire Register Port Master

This block lets on-chip logic read and write the internal registers of an external baseband device over a three-wire serial port. The port uses one shared data wire, an active-low chip select, a direction line and an envelope strobe. On the host side, a request is offered with a valid/ready handshake. The request carries a register address, write data and a read/write flag. Completion is signalled by a one-cycle done pulse. For reads, the returned byte is valid in the same cycle as that pulse.

The serial clock is produced by dividing the system clock by a programmable ratio. The ratio sits in a configuration register that resets to 14. Its value is copied into the divider only when a request is accepted, so a change never disturbs a transfer that is already running. Every line the block drives toward the slave changes on a falling serial-clock edge, so it is settled before the slave samples it on the next rising edge.

A write shifts out 7 address bits and then 8 data bits, most significant bit first, for 15 rising edges in total. A read shifts out the 7 address bits and then releases the wire for one turnaround period. It then captures 8 bits on the next 8 rising edges, for 16 rising edges in total.

Top module: `sreg_port_master`

## Requirements
- R1: For an effective ratio N, each serial-clock period lasts N system cycles. The clock is high for floor(N/2) cycles and low for N-floor(N/2) cycles.
- R2: The serial clock is low whenever chip select is deasserted.
- R3: While chip select stays low, the strobe, direction, data-out and output-enable lines change only in the system cycle in which the serial clock falls.
- R4: The strobe is 1 for every address bit (the first 7 rising edges) and 0 for every later rising edge of a transfer.
- R5: Chip select goes low in the cycle after acceptance. It precedes the first rising edge by N-floor(N/2) cycles and is released N-floor(N/2) cycles after the last falling edge.
- R6: The direction line is 1 for a read and 0 for a write, held for the whole transfer. It returns to 0 when chip select is released.
- R7: A write produces 15 rising edges that carry {address, data} MSB first, with the output enable high on every one of them.
- R8: A read produces 16 rising edges. The address goes out on the first 7 with the output enable high. The output enable is low from the 8th (turnaround) edge onward. The input is sampled on rising edges 9 to 16, MSB first.
- R9: Ready is high only while idle. A request offered during a transfer is dropped and does not start a later transfer.
- R10: Done is high for exactly one cycle, in the first cycle with chip select released. Read data is valid in that cycle.
- R11: After reset, chip select is high, the output enable is low, ready is high and the configured ratio is 14. An asynchronous reset in mid-transfer drops chip select at once.
- R12: A configured ratio of 0 or 1 behaves as 2.
- R13: A ratio written during a transfer leaves that transfer's timing unchanged and applies from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the ratio register |
| cfg_ratio | input | 8 | New clock division ratio |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_done |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| rw | output | 1 | Direction line, 1 = read |
| strobe | output | 1 | 1 during address bits, 0 during data bits |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the shared data wire |
| sdi | input | 1 | Serial data in |

## Verification
The hardest situations to reach from the ports are the ones that overlap a running transfer. These are a ratio write or a competing request arriving while the shifter is busy, and a reset landing between serial-clock edges. The bench drives these from inside its per-cycle monitor loop, at fixed cycle offsets after acceptance. It then checks the widths and bit patterns of that transfer and of the next one. The slave model drives read bits on observed falling edges only after the turnaround edge. A shifter that samples one edge early or late therefore returns a shifted byte.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_TAIL  = 2'd2
  } sq_state_e;

endpackage

// File: rtl/sreg_rst_sync.sv
module sreg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/sreg_ratio_reg.sv
module sreg_ratio_reg #(
  parameter int RATIO_W   = 8,
  parameter int DEF_RATIO = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RATIO_W-1:0] wr_val,
  input  logic               load,
  input  logic               busy,
  output logic [RATIO_W-1:0] ratio_o
);

  localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(2);
  localparam logic [RATIO_W-1:0] DEF_R = (DEF_RATIO < 2) ? MIN_R : RATIO_W'(DEF_RATIO);

  logic [RATIO_W-1:0] cfg_q, cfg_d;
  logic [RATIO_W-1:0] act_q, act_d;

  always_comb begin
    cfg_d = cfg_q;
    act_d = act_q;
    if (wr_en) cfg_d = (wr_val < MIN_R) ? MIN_R : wr_val;
    if (load)  act_d = cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= DEF_R;
      act_q <= DEF_R;
    end else begin
      cfg_q <= cfg_d;
      act_q <= act_d;
    end
  end

  assign ratio_o = act_q;

  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_o >= MIN_R); // R12
  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ratio_o)); // R13

endmodule

// File: rtl/sreg_clkgen.sv
module sreg_clkgen #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               rise_en,
  input  logic [RATIO_W-1:0] ratio,
  output logic               sck_o,
  output logic               rise_o,
  output logic               fall_o,
  output logic               mid_o
);

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic               sck_q, sck_d;
  logic [RATIO_W-1:0] lo_len;
  logic               at_mid, at_wrap;

  assign lo_len  = ratio - (ratio >> 1);
  assign at_mid  = (cnt_q == lo_len - RATIO_W'(1));
  assign at_wrap = (cnt_q == ratio - RATIO_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else begin
      if (at_wrap) cnt_d = '0;
      else         cnt_d = cnt_q + RATIO_W'(1);
      if (at_mid && rise_en) sck_d = 1'b1;
      else if (at_wrap)      sck_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = run && rise_en && at_mid;
  assign fall_o = run && at_wrap;
  assign mid_o  = run && at_mid;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio); // R1
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o)); // R1
  AST_SCK_REST: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sck_q); // R2

endmodule

// File: rtl/sreg_sequencer.sv
module sreg_sequencer
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              load_o,
  output logic              run_o,
  output logic              rise_en_o,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mid_i,
  input  logic              sdi,
  output logic              cs_n_o,
  output logic              rw_o,
  output logic              as_o,
  output logic              sdo_o,
  output logic              oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int TOT    = ADDR_W + DATA_W;
  localparam int SLOT_W = $clog2(TOT + 2);
  localparam logic [SLOT_W-1:0] LAST_WR = SLOT_W'(TOT - 1);
  localparam logic [SLOT_W-1:0] LAST_RD = SLOT_W'(TOT);
  localparam logic [SLOT_W-1:0] A_END   = SLOT_W'(ADDR_W);

  sq_state_e         state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d, slot_nx, slot_last;
  logic [TOT-1:0]    sh_q, sh_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              cs_n_q, cs_n_d;
  logic              rw_q, rw_d;
  logic              as_q, as_d;
  logic              oe_q, oe_d;
  logic              done_q, done_d;
  logic              accept;

  assign req_ready = (state_q == SQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign slot_nx   = slot_q + SLOT_W'(1);
  assign slot_last = rw_q ? LAST_RD : LAST_WR;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    sh_d    = sh_q;
    rx_d    = rx_q;
    cs_n_d  = cs_n_q;
    rw_d    = rw_q;
    as_d    = as_q;
    oe_d    = oe_q;
    done_d  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          state_d = SQ_SHIFT;
          slot_d  = '0;
          cs_n_d  = 1'b0;
          rw_d    = !req_write;
          as_d    = 1'b1;
          oe_d    = 1'b1;
          sh_d    = {req_addr, (req_write ? req_wdata : {DATA_W{1'b0}})};
          rx_d    = '0;
        end
      end
      SQ_SHIFT: begin
        if (rise_i && rw_q && (slot_q > A_END)) begin
          rx_d = {rx_q[DATA_W-2:0], sdi};
        end
        if (fall_i) begin
          if (slot_q == slot_last) begin
            state_d = SQ_TAIL;
            as_d    = 1'b0;
            oe_d    = 1'b0;
            sh_d    = '0;
          end else begin
            slot_d = slot_nx;
            sh_d   = {sh_q[TOT-2:0], 1'b0};
            as_d   = (slot_nx < A_END);
            oe_d   = rw_q ? (slot_nx < A_END) : 1'b1;
          end
        end
      end
      SQ_TAIL: begin
        if (mid_i) begin
          state_d = SQ_IDLE;
          cs_n_d  = 1'b1;
          rw_d    = 1'b0;
          done_d  = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      slot_q  <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      cs_n_q  <= 1'b1;
      rw_q    <= 1'b0;
      as_q    <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      sh_q    <= sh_d;
      rx_q    <= rx_d;
      cs_n_q  <= cs_n_d;
      rw_q    <= rw_d;
      as_q    <= as_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
    end
  end

  assign load_o    = accept;
  assign run_o     = (state_q != SQ_IDLE);
  assign rise_en_o = (state_q == SQ_SHIFT);
  assign cs_n_o    = cs_n_q;
  assign rw_o      = rw_q;
  assign as_o      = as_q;
  assign sdo_o     = sh_q[TOT-1];
  assign oe_o      = oe_q;
  assign done_o    = done_q;
  assign rdata_o   = rx_q;

  AST_LINES_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_q && $past(!cs_n_q) && !$past(fall_i)) |->
      ($stable(as_q) && $stable(oe_q) && $stable(sh_q[TOT-1]) && $stable(rw_q))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cs_n_q && $past(!cs_n_q))); // R10
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n_q && !oe_q)); // R9
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_q && rw_q && !as_q) |-> !oe_q); // R8
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SHIFT && !rw_q) |-> oe_q); // R7

endmodule

// File: rtl/sreg_port_master.sv
module sreg_port_master #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int RATIO_W   = 8,
  parameter int DEF_RATIO = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_done,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               sck,
  output logic               cs_n,
  output logic               rw,
  output logic               strobe,
  output logic               sdo,
  output logic               sdo_oe,
  input  logic               sdi
);

  logic               rst_sync_n;
  logic [RATIO_W-1:0] ratio_act;
  logic               load, run, rise_en, rise, fall, mid;

  sreg_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n  (rst_sync_n)
  );

  sreg_ratio_reg #(.RATIO_W(RATIO_W), .DEF_RATIO(DEF_RATIO)) u_ratio (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we),
    .wr_val  (cfg_ratio),
    .load    (load),
    .busy    (run),
    .ratio_o (ratio_act)
  );

  sreg_clkgen #(.RATIO_W(RATIO_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (run),
    .rise_en (rise_en),
    .ratio   (ratio_act),
    .sck_o   (sck),
    .rise_o  (rise),
    .fall_o  (fall),
    .mid_o   (mid)
  );

  sreg_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .load_o    (load),
    .run_o     (run),
    .rise_en_o (rise_en),
    .rise_i    (rise),
    .fall_i    (fall),
    .mid_i     (mid),
    .sdi       (sdi),
    .cs_n_o    (cs_n),
    .rw_o      (rw),
    .as_o      (strobe),
    .sdo_o     (sdo),
    .oe_o      (sdo_oe),
    .done_o    (rsp_done),
    .rdata_o   (rsp_rdata)
  );

endmodule

// File: tb/sreg_port_master_bench.sv
module sreg_port_master_bench;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_ratio;
  logic       req_valid;
  logic       req_ready;
  logic       req_write;
  logic [6:0] req_addr;
  logic [7:0] req_wdata;
  logic       rsp_done;
  logic [7:0] rsp_rdata;
  logic       sck, cs_n, rw, strobe, sdo, sdo_oe, sdi;

  int checks = 0;
  int errors = 0;

  sreg_port_master u_sreg_port_master (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ratio(cfg_ratio),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .sck(sck), .cs_n(cs_n), .rw(rw),
    .strobe(strobe), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {write, addr, wdata, slave byte, ratio write enable, ratio, effective ratio}
  localparam int NV = 8;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 7'h2A, 8'hC3, 8'h00, 1'b0, 8'd0,  8'd14},
    {1'b0, 7'h15, 8'h00, 8'h5A, 1'b1, 8'd4,  8'd4},
    {1'b1, 7'h7F, 8'h01, 8'h00, 1'b1, 8'd3,  8'd3},
    {1'b0, 7'h40, 8'h00, 8'hA5, 1'b1, 8'd1,  8'd2},
    {1'b1, 7'h00, 8'hFF, 8'h00, 1'b1, 8'd0,  8'd2},
    {1'b0, 7'h7F, 8'h00, 8'h81, 1'b1, 8'd5,  8'd5},
    {1'b0, 7'h01, 8'h00, 8'hFF, 1'b0, 8'd0,  8'd5},
    {1'b1, 7'h55, 8'h80, 8'h00, 1'b1, 8'd2,  8'd2}
  };

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_ratio(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_ratio = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xfer(input bit w, input logic [6:0] a, input logic [7:0] wd,
                      input logic [7:0] sd, input int eff, input bit poke,
                      input bit mid_en, input logic [7:0] mid_val);
    int hi, lo, rises, lo_run, hi_run, wbad, sbad, rwbad, setup;
    logic [15:0] bits, aspat, oepat;
    logic p_sck, p_as, p_sdo, p_oe, p_rw;
    bit ended;
    hi = eff / 2; lo = eff - hi;
    rises = 0; hi_run = 0; wbad = 0; sbad = 0; rwbad = 0; setup = -1;
    bits = '0; aspat = '0; oepat = '0; ended = 0; sdi = 1'b0;
    @(negedge clk);
    req_write = w; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    chk("R9 ready high while idle", req_ready == 1'b1, req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 chip select low after accept", cs_n == 1'b0, cs_n, 0);
    p_sck = sck; p_as = strobe; p_sdo = sdo; p_oe = sdo_oe; p_rw = rw;
    lo_run = 1;
    for (int cyc = 0; cyc < 6000 && !ended; cyc++) begin
      if (poke && cyc == 3) begin
        chk("R9 ready low while busy", req_ready == 1'b0, req_ready, 0);
        req_addr = a ^ 7'h55; req_write = !w; req_valid = 1'b1;
      end
      if (poke && cyc == 4) req_valid = 1'b0;
      if (mid_en && cyc == 4) begin cfg_we = 1'b1; cfg_ratio = mid_val; end
      if (mid_en && cyc == 5) cfg_we = 1'b0;
      @(negedge clk);
      if (cs_n) begin
        ended = 1;
        chk("R5 chip select held after last fall", lo_run == lo, lo_run, lo);
        chk("R10 done with chip select release", rsp_done == 1'b1, rsp_done, 1);
        chk("R2 clock low at release", sck == 1'b0, sck, 0);
        if (!w) chk("R8 read data", rsp_rdata == sd, rsp_rdata, sd);
      end else begin
        if (!(p_sck && !sck) &&
            (strobe != p_as || sdo != p_sdo || sdo_oe != p_oe || rw != p_rw)) sbad++;
        if (sck && !p_sck) begin
          if (setup < 0) setup = lo_run;
          else if (lo_run != lo) wbad++;
          bits  = {bits[14:0], sdo};
          aspat = {aspat[14:0], strobe};
          oepat = {oepat[14:0], sdo_oe};
          if (rw != !w) rwbad++;
          rises++;
          hi_run = 1;
        end else if (!sck && p_sck) begin
          if (hi_run != hi) wbad++;
          lo_run = 1;
          if (!w && rises >= 8 && rises <= 15) sdi = sd[15 - rises];
        end else if (sck) hi_run++;
        else lo_run++;
        p_sck = sck; p_as = strobe; p_sdo = sdo; p_oe = sdo_oe; p_rw = rw;
      end
    end
    if (!ended) chk("R10 transfer completes", 1'b0, 0, 1);
    chk("R1 clock high and low widths", wbad == 0, wbad, 0);
    chk("R5 chip select setup before first rise", setup == lo, setup, lo);
    chk("R3 lines change only at falling edge", sbad == 0, sbad, 0);
    chk("R6 direction held for transfer", rwbad == 0, rwbad, 0);
    chk("R6 direction back to 0", rw == 1'b0, rw, 0);
    if (w) begin
      chk("R7 write edge count", rises == 15, rises, 15);
      chk("R7 write bits", bits[14:0] == {a, wd}, bits[14:0], {a, wd});
      chk("R4 strobe write pattern", aspat[14:0] == 15'h7F00, aspat[14:0], 15'h7F00);
      chk("R7 output enable on all bits", oepat[14:0] == 15'h7FFF, oepat[14:0], 15'h7FFF);
    end else begin
      chk("R8 read edge count", rises == 16, rises, 16);
      chk("R8 read address bits", bits[15:9] == a, bits[15:9], a);
      chk("R4 strobe read pattern", aspat == 16'hFE00, aspat, 16'hFE00);
      chk("R8 output released from turnaround", oepat == 16'hFE00, oepat, 16'hFE00);
    end
    @(negedge clk);
    chk("R10 done lasts one cycle", rsp_done == 1'b0, rsp_done, 0);
    repeat (3) @(negedge clk);
    chk("R9 dropped request starts nothing", cs_n == 1'b1 && req_ready == 1'b1, cs_n, 1);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ratio = '0; req_valid = 1'b0;
    req_write = 1'b0; req_addr = '0; req_wdata = '0; sdi = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 reset chip select high", cs_n == 1'b1, cs_n, 1);
    chk("R11 reset output disabled", sdo_oe == 1'b0, sdo_oe, 0);
    chk("R11 reset ready", req_ready == 1'b1, req_ready, 1);
    chk("R2 reset clock low", sck == 1'b0, sck, 0);
    chk("R6 reset direction", rw == 1'b0, rw, 0);
    chk("R10 reset done low", rsp_done == 1'b0, rsp_done, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) set_ratio(VEC[i][15:8]);
      xfer(VEC[i][40], VEC[i][39:33], VEC[i][32:25], VEC[i][24:17],
           int'(VEC[i][7:0]), 1'b0, 1'b0, 8'd0);
    end

    // R13 and R9: ratio write and competing request during a transfer
    set_ratio(8'd4);
    xfer(1'b0, 7'h33, 8'h00, 8'h3C, 4, 1'b1, 1'b1, 8'd6);
    xfer(1'b1, 7'h0C, 8'h96, 8'h00, 6, 1'b1, 1'b0, 8'd0);

    // R11: asynchronous reset in mid-transfer, then default ratio again
    @(negedge clk);
    req_write = 1'b1; req_addr = 7'h11; req_wdata = 8'h22; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (9) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 mid-transfer reset drops chip select", cs_n == 1'b1, cs_n, 1);
    chk("R11 mid-transfer reset disables output", sdo_oe == 1'b0, sdo_oe, 0);
    chk("R2 mid-transfer reset clock low", sck == 1'b0, sck, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 ready after reset", req_ready == 1'b1, req_ready, 1);
    xfer(1'b0, 7'h5E, 8'h00, 8'h69, 14, 1'b0, 1'b0, 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule